// File: doc/BRIEF.md
# Conversion Sample Queue with Fill-Level Interrupt

This block sits between an analog converter and a host that only has an 8-bit register bus. Each strobe from the converter side pushes one 16-bit result into a 2048-word first-in first-out store. The host takes the oldest word in two byte reads. The upper byte is read first, which also latches the word. The lower byte read then returns the rest of that word and removes it from the store.

The host can read the number of stored words at any time, along with a status byte. It programs a fill-level threshold. It picks one of two interrupt sources: the threshold crossing, when queue mode is on, or every conversion strobe, when queue mode is off. Writing a clear bit empties the store and drops the overflow record.

Top module: `adc_sample_fifo`

## Requirements
- R1: Words are returned in the order they were written. The store holds up to 2048 words, and each accepted write or pop changes the stored count by exactly one.
- R2: A read of register 1 returns bits 15..8 of the oldest word and latches that word. A following read of register 0 returns bits 7..0 of the latched word and pops the oldest word.
- R3: Register 2 reads count bits 7..0. Register 3 reads count bits 11..8 in bits 3..0, and its bits 7..4 read as zero.
- R4: A conversion strobe that arrives while 2048 words are stored is dropped. The count does not change, and a sticky overflow flag is set.
- R5: Popping an empty store leaves the count at zero. While the store is empty, a read of register 1 returns the upper byte of the last word that was popped, or zero if no word has been popped since reset.
- R6: Writing register 6 with bit 0 set empties the store and clears the overflow flag.
- R7: Registers 4 and 5 hold a 10-bit threshold field T. Register 4 holds T bits 7..0, and register 5 bits 1..0 hold T bits 9..8. The threshold flag is 1 when T is not zero and the count is at least 2*T. When T is zero the flag stays 0.
- R8: A read of register 6 returns the status byte. Bit 7 is the queue-mode enable, bit 3 is empty, bit 2 is the threshold flag, bit 1 is full and bit 0 is overflow. Bits 6..4 read as zero.
- R9: A register 6 write sets queue mode from bit 7 and interrupt enable from bit 6. With both set, a rise of the threshold flag makes the interrupt pending one cycle later.
- R10: With queue mode off and interrupt enable on, every conversion strobe makes the interrupt pending.
- R11: The pending interrupt drives `irq` and reads back as register 7 bit 0. Writing register 7 with bit 0 set clears it. While interrupt enable is off, nothing makes it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_valid | input | 1 | Conversion result strobe |
| conv_data | input | 16 | Conversion result |
| bus_sel | input | 3 | Register index |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
Some properties are checked on every cycle:
- The count never exceeds the depth and never steps by more than one.
- A write into a full store leaves it full.
- Overflow persists until a clear.
- An empty pop leaves the read pointer alone.
- A clear lands one cycle later.
- Both interrupt sources and the enable mask behave as specified.

Other behaviour can only be shown by the bench scenarios, which compare each result with a queue model:
- the data order across a full fill and drain;
- the byte split of the word and of the count;
- the stale value returned when the store is empty;
- the exact count at which the threshold flag switches.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;

   typedef enum logic [2:0] {
      RG_DATA_LO = 3'd0,
      RG_DATA_HI = 3'd1,
      RG_CNT_LO  = 3'd2,
      RG_CNT_HI  = 3'd3,
      RG_THR_LO  = 3'd4,
      RG_THR_HI  = 3'd5,
      RG_CTRL    = 3'd6,
      RG_IRQ     = 3'd7
   } reg_idx_e;

   localparam int unsigned CTRL_QMODE_BIT = 7;
   localparam int unsigned CTRL_IEN_BIT   = 6;
   localparam int unsigned CTRL_CLR_BIT   = 0;
   localparam int unsigned IRQ_PEND_BIT   = 0;

   typedef struct packed {
      logic       qmode;
      logic [2:0] zero;
      logic       empty;
      logic       thr;
      logic       full;
      logic       ovr;
   } status_t;

endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 2048
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     wr_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   input  logic                     pop_i,
   output logic [DATA_W-1:0]        head_o,
   output logic [$clog2(DEPTH):0]   count_o,
   output logic                     empty_o,
   output logic                     full_o,
   output logic                     ovr_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = PTR_W + 1;
   localparam bit          POW2  = ((1 << PTR_W) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("adc_fifo_store: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_inc, rd_inc;
   logic [CNT_W-1:0]  count_q;
   logic              ovr_q;
   logic              wr_ok, pop_ok;

   generate
      if (POW2) begin : g_pow2
         assign wr_inc = wr_ptr_q + PTR_W'(1);
         assign rd_inc = rd_ptr_q + PTR_W'(1);
      end else begin : g_wrap
         assign wr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
         assign rd_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
      end
   endgenerate

   assign empty_o = (count_q == '0);
   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign wr_ok   = wr_i  && !full_o  && !clr_i;
   assign pop_ok  = pop_i && !empty_o && !clr_i;
   assign head_o  = mem[rd_ptr_q];
   assign count_o = count_q;
   assign ovr_o   = ovr_q;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr_q] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         ovr_q    <= 1'b0;
      end else if (clr_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         ovr_q    <= 1'b0;
      end else begin
         if (wr_ok)  wr_ptr_q <= wr_inc;
         if (pop_ok) rd_ptr_q <= rd_inc;
         if (wr_i && full_o) ovr_q <= 1'b1;
         case ({wr_ok, pop_ok})
            2'b10:   count_q <= count_q + CNT_W'(1);
            2'b01:   count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1))
                 || (count_q == $past(count_q) - CNT_W'(1)));
   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && wr_i && !pop_i && !clr_i) |=> (full_o && ovr_o));
   a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && !clr_i) |=> ovr_o);
   a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i) |=> $stable(rd_ptr_q));
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (empty_o && !ovr_o));

endmodule

// File: rtl/adc_fifo_irq.sv
module adc_fifo_irq #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned THR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             qmode_i,
   input  logic             ien_i,
   input  logic             conv_i,
   input  logic             ack_i,
   output logic             thr_flag_o,
   output logic             pend_o
);
   generate
      if (CNT_W < THR_W + 1) begin : g_bad_thr
         $error("adc_fifo_irq: count too narrow for the threshold field");
      end
   endgenerate

   logic [CNT_W-1:0] thr_words;
   logic             thr_prev_q, pend_q, set_evt;

   assign thr_words  = CNT_W'({thr_i, 1'b0});
   assign thr_flag_o = (thr_i != '0) && (count_i >= thr_words);
   assign set_evt    = ien_i && (qmode_i ? (thr_flag_o && !thr_prev_q) : conv_i);
   assign pend_o     = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_prev_q <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         thr_prev_q <= thr_flag_o;
         if (set_evt)    pend_q <= 1'b1;
         else if (ack_i) pend_q <= 1'b0;
      end
   end

   a_r9_thr_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (qmode_i && ien_i && thr_flag_o && !thr_prev_q) |=> pend_o);
   a_r10_per_conv: assert property (@(posedge clk) disable iff (!rst_n)
      (!qmode_i && ien_i && conv_i) |=> pend_o);
   a_r11_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_i && !pend_o) |=> !pend_o);
   a_r11_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !ien_i) |=> !pend_o);

endmodule

// File: rtl/adc_fifo_regs.sv
module adc_fifo_regs
   import adc_fifo_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned THR_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sel_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic [DATA_W-1:0] head_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              empty_i,
   input  logic              full_i,
   input  logic              ovr_i,
   input  logic              thr_flag_i,
   input  logic              pend_i,
   output logic              pop_o,
   output logic              clr_o,
   output logic              ack_o,
   output logic              qmode_o,
   output logic              ien_o,
   output logic [THR_W-1:0]  thr_o
);
   localparam int unsigned EXT_W = 2 * BYTE_W;

   generate
      if (DATA_W != EXT_W) begin : g_bad_data
         $error("adc_fifo_regs: data word must be two bytes");
      end
      if (CNT_W <= BYTE_W || CNT_W > EXT_W) begin : g_bad_cnt
         $error("adc_fifo_regs: count must span two bytes");
      end
      if (THR_W <= BYTE_W || THR_W > EXT_W) begin : g_bad_thr
         $error("adc_fifo_regs: threshold must span two bytes");
      end
   endgenerate

   reg_idx_e          idx;
   logic [DATA_W-1:0] hold_q;
   logic [THR_W-1:0]  thr_q;
   logic              qmode_q, ien_q;
   logic [EXT_W-1:0]  cnt_ext, thr_ext;
   logic [DATA_W-1:0] hi_src;
   status_t           stat;
   logic              hi_rd;

   assign idx     = reg_idx_e'(sel_i);
   assign cnt_ext = EXT_W'(count_i);
   assign thr_ext = EXT_W'(thr_q);
   assign hi_src  = empty_i ? hold_q : head_i;
   assign hi_rd   = rd_i && (idx == RG_DATA_HI);
   assign pop_o   = rd_i && (idx == RG_DATA_LO);
   assign clr_o   = wr_i && (idx == RG_CTRL) && wdata_i[CTRL_CLR_BIT];
   assign ack_o   = wr_i && (idx == RG_IRQ)  && wdata_i[IRQ_PEND_BIT];
   assign qmode_o = qmode_q;
   assign ien_o   = ien_q;
   assign thr_o   = thr_q;

   always_comb begin
      stat       = '0;
      stat.qmode = qmode_q;
      stat.empty = empty_i;
      stat.thr   = thr_flag_i;
      stat.full  = full_i;
      stat.ovr   = ovr_i;
   end

   always_comb begin
      rdata_o = '0;
      case (idx)
         RG_DATA_LO: rdata_o = hold_q[BYTE_W-1:0];
         RG_DATA_HI: rdata_o = hi_src[DATA_W-1:BYTE_W];
         RG_CNT_LO:  rdata_o = cnt_ext[BYTE_W-1:0];
         RG_CNT_HI:  rdata_o = cnt_ext[EXT_W-1:BYTE_W];
         RG_THR_LO:  rdata_o = thr_ext[BYTE_W-1:0];
         RG_THR_HI:  rdata_o = thr_ext[EXT_W-1:BYTE_W];
         RG_CTRL:    rdata_o = BYTE_W'(stat);
         RG_IRQ:     rdata_o = BYTE_W'(pend_i);
         default:    rdata_o = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         thr_q   <= '0;
         qmode_q <= 1'b0;
         ien_q   <= 1'b0;
      end else begin
         if (hi_rd && !empty_i) hold_q <= head_i;
         if (wr_i) begin
            case (idx)
               RG_THR_LO: thr_q[BYTE_W-1:0]     <= wdata_i;
               RG_THR_HI: thr_q[THR_W-1:BYTE_W] <= wdata_i[THR_W-BYTE_W-1:0];
               RG_CTRL: begin
                  qmode_q <= wdata_i[CTRL_QMODE_BIT];
                  ien_q   <= wdata_i[CTRL_IEN_BIT];
               end
               default: ;
            endcase
         end
      end
   end

   a_r2_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && !empty_i) |=> (hold_q == $past(head_i)));
   a_r2_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_rd |=> $stable(hold_q));

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned THR_W  = 10,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic [2:0]        bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  count;
   logic [THR_W-1:0]  thr;
   logic empty, full, ovr, thr_flag, pend;
   logic pop, clr, ack, qmode, ien;

   adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(conv_valid),
      .wr_data_i(conv_data), .pop_i(pop), .head_o(head), .count_o(count),
      .empty_o(empty), .full_o(full), .ovr_o(ovr)
   );

   adc_fifo_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) irq_i (
      .clk(clk), .rst_n(rst_n), .count_i(count), .thr_i(thr),
      .qmode_i(qmode), .ien_i(ien), .conv_i(conv_valid), .ack_i(ack),
      .thr_flag_o(thr_flag), .pend_o(pend)
   );

   adc_fifo_regs #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .THR_W(THR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .rd_i(bus_rd), .wr_i(bus_wr),
      .wdata_i(bus_wdata), .rdata_o(bus_rdata), .head_i(head), .count_i(count),
      .empty_i(empty), .full_i(full), .ovr_i(ovr), .thr_flag_i(thr_flag),
      .pend_i(pend), .pop_o(pop), .clr_o(clr), .ack_o(ack), .qmode_o(qmode),
      .ien_o(ien), .thr_o(thr)
   );

   assign irq = pend;

endmodule

// File: tb/adc_sample_fifo_tb_top.sv
module adc_sample_fifo_tb_top;
   localparam int DEPTH = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_valid = 1'b0;
   logic [15:0] conv_data = '0;
   logic [2:0]  bus_sel = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model
   int          q[$];
   bit          m_ovr = 0, m_qmode = 0, m_ien = 0, m_pend = 0, m_prev = 0;
   int          m_thr = 0;
   logic [15:0] m_last = '0;

   always #5 clk = ~clk;

   adc_sample_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic bit m_flag();
      return (m_thr != 0) && (q.size() >= 2 * m_thr);
   endfunction

   function automatic logic [7:0] m_status();
      return {m_qmode, 3'b000, q.size() == 0, m_flag(), q.size() == DEPTH, m_ovr};
   endfunction

   function automatic void m_tick();
      bit now = m_flag();
      if (m_qmode && m_ien && now && !m_prev) m_pend = 1;
      m_prev = now;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [2:0] sel, output logic [7:0] d);
      @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic conv_write(input logic [15:0] d);
      @(negedge clk); conv_data = d; conv_valid = 1'b1;
      @(negedge clk); conv_valid = 1'b0;
      @(negedge clk);
      if (!m_qmode && m_ien) m_pend = 1;
      if (q.size() == DEPTH) m_ovr = 1; else q.push_back(int'(d));
      m_tick();
   endtask

   task automatic set_ctrl(input bit qm, input bit ie, input bit clr);
      bus_write(3'd6, {qm, ie, 5'b0, clr});
      m_qmode = qm; m_ien = ie;
      if (clr) begin q.delete(); m_ovr = 0; end
      m_tick();
   endtask

   task automatic set_thr(input int t);
      bus_write(3'd4, t[7:0]);
      bus_write(3'd5, {6'b0, t[9:8]});
      m_thr = t;
      m_tick();
   endtask

   task automatic ack_irq();
      bus_write(3'd7, 8'h01);
      m_pend = 0;
      m_tick();
   endtask

   task automatic pop_check(input string req);
      logic [7:0] hi, lo;
      logic [15:0] exp;
      bus_read(3'd1, hi);
      bus_read(3'd0, lo);
      if (q.size() != 0) m_last = 16'(q.pop_front());
      exp = m_last;
      m_tick();
      check({hi, lo} == exp, req, {hi, lo}, exp);
   endtask

   task automatic count_check(input string req);
      logic [7:0] lo, hi;
      bus_read(3'd2, lo);
      bus_read(3'd3, hi);
      check({hi, lo} == 16'(q.size()) && hi[7:4] == 4'h0, req, {hi, lo}, q.size());
   endtask

   task automatic status_check(input string req);
      logic [7:0] s;
      bus_read(3'd6, s);
      check(s == m_status(), req, s, m_status());
   endtask

   task automatic irq_check(input string req);
      logic [7:0] r;
      bus_read(3'd7, r);
      check(r == {7'b0, m_pend} && irq == m_pend, req, {irq, r}, {m_pend, 7'b0, m_pend});
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 R3 R11: reset state
      status_check("R8 reset status");
      count_check("R3 reset count");
      irq_check("R11 reset irq");

      // R1 R2: order and byte split
      conv_write(16'hA1B2); conv_write(16'h1234); conv_write(16'hFF00);
      count_check("R3 count three");
      pop_check("R1 R2 first word");
      pop_check("R1 R2 second word");
      pop_check("R1 R2 third word");

      // R5: empty pop returns last word
      pop_check("R5 empty pop");
      count_check("R5 count stays zero");
      bus_read(3'd1, d);
      check(d == 8'hFF, "R5 empty high byte", d, 8'hFF);

      // R7 R9: threshold of 2 -> 4 words
      set_ctrl(1'b1, 1'b1, 1'b0);
      set_thr(2);
      conv_write(16'h0001); conv_write(16'h0002); conv_write(16'h0003);
      status_check("R7 below threshold");
      irq_check("R9 no irq below threshold");
      conv_write(16'h0004);
      status_check("R7 at threshold");
      irq_check("R9 irq on threshold rise");
      bus_read(3'd4, d);
      check(d == 8'h02, "R7 threshold readback", d, 8'h02);
      set_thr(0);
      status_check("R7 zero threshold disables flag");
      ack_irq();
      irq_check("R11 ack clears");

      // R10 R11: per conversion mode
      set_ctrl(1'b0, 1'b1, 1'b1);
      status_check("R6 clear empties");
      conv_write(16'h5555);
      irq_check("R10 per conversion");
      ack_irq();
      set_ctrl(1'b0, 1'b0, 1'b0);
      conv_write(16'h6666);
      irq_check("R11 masked");

      // R4 R3 R8 R6: full and overflow
      set_ctrl(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < DEPTH; i++) conv_write(16'(i * 7 + 3));
      count_check("R3 full count");
      status_check("R8 full status");
      conv_write(16'hDEAD);
      count_check("R4 dropped write");
      status_check("R4 overflow set");
      for (int i = 0; i < DEPTH; i++) pop_check("R1 drain order");
      status_check("R4 overflow sticky after drain");
      set_ctrl(1'b1, 1'b0, 1'b1);
      status_check("R6 clear drops overflow");

      // random phase
      set_ctrl(1'b1, 1'b1, 1'b0);
      set_thr(3);
      for (int i = 0; i < 600; i++) begin
         int op = $urandom_range(0, 11);
         if (op < 5) conv_write(16'($urandom()));
         else if (op < 8) pop_check("R1 R2 random pop");
         else if (op == 8) count_check("R3 random count");
         else if (op == 9) status_check("R8 random status");
         else if (op == 10) irq_check("R9 random irq");
         else begin
            if ($urandom_range(0, 1) == 1) ack_irq(); else set_thr($urandom_range(1, 6));
         end
      end
      irq_check("R11 final irq");
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule